// File: doc/BRIEF.md
# Debug Probe Target Reset Sequencer

This block runs the reset-and-startup sequence that a debug probe applies to its target. It starts on its own when its reset is released, and again whenever `start_req` is pulsed. A sequence drives the target system reset and the test-logic reset low together for a programmable number of milliseconds. It then releases both and waits a programmable settling time. After that it follows one of three startup policies.

In the halt policy the debug logic is told to halt the core at once. In the timed policy the target first runs for a bounded window of milliseconds and is then halted. In both of these, a one-cycle "start init list" strobe follows the halt strobe, and `ready` comes up after it. In the free-run policy the target is left running: no halt and no init strobe are sent, and only `ready` comes up.

A one-cycle `ms_tick` input times every phase. The configuration is captured once, when a sequence starts from rest. The system reset pin behaves as an open-collector line: it has only a pull-low enable. The test-reset pin can be open-drain or push-pull.

Top module: `probe_reset_sequencer`

## Requirements
- R1: When `rst_n` is released, a sequence starts without a request. It uses the configuration present in the first cycle after release. During the assert phase the test-reset line is driven low (`trst_oe`=1, `trst_o`=0).
- R2: The assert phase lasts exactly `cfg_pulse_ms` ticks of `ms_tick`. A value of 0 selects the default of 3 ticks.
- R3: After release, `cfg_settle_ms` ticks pass before the policy continues with a halt, a run window or `ready`.
- R4: Halt policy (`cfg_mode`=2'b00): after settling, `halt_req` pulses for one cycle. `init_start` pulses in the next cycle and `ready` rises in the cycle after that.
- R5: Timed policy (`cfg_mode`=2'b01): after settling, the target runs for `cfg_run_ms` ticks, limited to the range 100..32000. The strobes of R4 then follow.
- R6: Free-run policy (`cfg_mode`=2'b10 or 2'b11): `ready` rises once settling ends. `halt_req` and `init_start` never pulse.
- R7: With `cfg_sysrst_en`=0, `sysrst_oe` is never asserted, and every phase length is unchanged.
- R8: The system reset pin only pulls low. `sysrst_oe` is high only during the assert phase, and the pin never drives high.
- R9: With `cfg_trst_pushpull`=0 (open-drain), `trst_oe` is high only while test reset is asserted, and `trst_o` is 0 whenever `trst_oe` is high. With 1 (push-pull), `trst_oe` stays high, and `trst_o` is 1 outside the assert phase.
- R10: Configuration inputs are sampled only when a sequence starts from rest. Changes made later have no effect on the running sequence or on the finished state.
- R11: A `start_req` during a sequence restarts it from the assert phase with the held configuration. A `start_req` at rest starts a new sequence with freshly sampled configuration.
- R12: `halt_req`, `init_start` and `ready` are never high together. `ready` holds until the next `start_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release launches the first sequence |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| start_req | input | 1 | Request to run (or restart) the sequence |
| cfg_mode | input | 2 | Startup policy: 00 halt, 01 timed run then halt, 1x free run |
| cfg_pulse_ms | input | MS_W | Reset assert length in ms, 0 = default |
| cfg_settle_ms | input | MS_W | Wait after release in ms |
| cfg_run_ms | input | MS_W | Run window in ms for the timed policy |
| cfg_sysrst_en | input | 1 | 1 = drive the system reset low during assert |
| cfg_trst_pushpull | input | 1 | 1 = push-pull test reset, 0 = open-drain |
| sysrst_oe | output | 1 | Pull-low enable of the system reset line |
| trst_oe | output | 1 | Output enable of the test reset line |
| trst_o | output | 1 | Driven level of the test reset line |
| halt_req | output | 1 | One-cycle request to halt the core |
| init_start | output | 1 | One-cycle strobe to start the init list |
| ready | output | 1 | Sequence finished, debug logic owns the target |

## Verification
The hardest situation to reach is a restart that arrives in the middle of a timed run window while the configuration inputs have already been changed. The bench waits until it sees test reset released. It lets part of the run window pass, changes every configuration input, and then pulses `start_req`. The restarted sequence must keep the old pulse, settle and window lengths, and must still be in the timed policy. A second request at rest must then pick up the new values. The upper limit of the run window costs 32000 ticks, so the tick is made as dense as the one-cycle strobe spacing allows.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_ARM,     // capture configuration, one cycle
    ST_ASSERT,  // both resets low
    ST_SETTLE,  // wait after release
    ST_RUNWIN,  // timed run before halt
    ST_HALT,    // halt strobe
    ST_INIT,    // init-list strobe
    ST_DONE     // handed over
  } seq_state_e;

  localparam logic [1:0] POLICY_HALT  = 2'b00;
  localparam logic [1:0] POLICY_TIMED = 2'b01;

  localparam int NUM_PINS = 2;
  localparam int PIN_SYS  = 0;
  localparam int PIN_TRST = 1;

  // Reset pulse length: zero selects the default length.
  function automatic int unsigned eff_pulse(input int unsigned req, input int unsigned dflt);
    return (req == 0) ? dflt : req;
  endfunction

  // Run window limited to the legal range.
  function automatic int unsigned clamp_window(input int unsigned req, input int unsigned lo,
                                               input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // A phase ends when its target is zero, or when this tick completes the count.
  function automatic logic phase_reached(input int unsigned count, input logic tick,
                                         input int unsigned target);
    return (target == 0) || (tick && (count + 1 >= target));
  endfunction

endpackage

// File: rtl/rsq_ms_timer.sv
module rsq_ms_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic         expire
);
  import rsq_pkg::*;

  logic [W-1:0] count_q;

  assign expire = phase_reached(32'(count_q), tick, 32'(target));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (tick && !(&count_q)) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsq_pin_drive.sv
module rsq_pin_drive #(
  parameter int N = 2
) (
  input  logic [N-1:0] assert_i,
  input  logic [N-1:0] enable_i,
  input  logic [N-1:0] pushpull_i,
  output logic [N-1:0] oe_o,
  output logic [N-1:0] level_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic pull_low;
    assign pull_low   = assert_i[p] & enable_i[p];
    // open-drain: enable only to pull low; push-pull: always driven
    assign oe_o[p]    = pushpull_i[p] | pull_low;
    assign level_o[p] = pushpull_i[p] & ~pull_low;
  end
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl #(
  parameter int MS_W         = 16,
  parameter int DEF_PULSE_MS = 3,
  parameter int RUN_MIN_MS   = 100,
  parameter int RUN_MAX_MS   = 32000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_req,
  input  logic                   phase_done,
  input  logic [1:0]             cfg_mode,
  input  logic [MS_W-1:0]        cfg_pulse_ms,
  input  logic [MS_W-1:0]        cfg_settle_ms,
  input  logic [MS_W-1:0]        cfg_run_ms,
  input  logic                   cfg_sysrst_en,
  input  logic                   cfg_trst_pushpull,
  output rsq_pkg::seq_state_e    state_o,
  output logic                   phase_enter,
  output logic [MS_W-1:0]        phase_target,
  output logic                   sys_en_q,
  output logic                   pp_q
);
  import rsq_pkg::*;

  seq_state_e      state_q, state_d;
  logic [1:0]      mode_q;
  logic [MS_W-1:0] pulse_q, settle_q, run_q;
  logic            restart;

  assign restart = start_req && (state_q != ST_DONE) && (state_q != ST_ARM);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARM:    state_d = ST_ASSERT;
      ST_ASSERT: if (phase_done) state_d = ST_SETTLE;
      ST_SETTLE: if (phase_done) begin
        if (mode_q == POLICY_HALT)       state_d = ST_HALT;
        else if (mode_q == POLICY_TIMED) state_d = ST_RUNWIN;
        else                             state_d = ST_DONE;
      end
      ST_RUNWIN: if (phase_done) state_d = ST_HALT;
      ST_HALT:   state_d = ST_INIT;
      ST_INIT:   state_d = ST_DONE;
      ST_DONE:   if (start_req) state_d = ST_ARM;
      default:   state_d = ST_ARM;
    endcase
    if (restart) state_d = ST_ASSERT;
  end

  assign phase_enter = (state_d != state_q) || restart;

  always_comb begin
    unique case (state_q)
      ST_ASSERT: phase_target = pulse_q;
      ST_SETTLE: phase_target = settle_q;
      ST_RUNWIN: phase_target = run_q;
      default:   phase_target = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ARM;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= POLICY_HALT;
      pulse_q  <= MS_W'(DEF_PULSE_MS);
      settle_q <= '0;
      run_q    <= MS_W'(RUN_MIN_MS);
      sys_en_q <= 1'b1;
      pp_q     <= 1'b0;
    end else if (state_q == ST_ARM) begin
      mode_q   <= cfg_mode;
      pulse_q  <= MS_W'(eff_pulse(32'(cfg_pulse_ms), DEF_PULSE_MS));
      settle_q <= cfg_settle_ms;
      run_q    <= MS_W'(clamp_window(32'(cfg_run_ms), RUN_MIN_MS, RUN_MAX_MS));
      sys_en_q <= cfg_sysrst_en;
      pp_q     <= cfg_trst_pushpull;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/probe_reset_sequencer.sv
module probe_reset_sequencer #(
  parameter int MS_W         = 16,
  parameter int DEF_PULSE_MS = 3,
  parameter int RUN_MIN_MS   = 100,
  parameter int RUN_MAX_MS   = 32000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic            start_req,
  input  logic [1:0]      cfg_mode,
  input  logic [MS_W-1:0] cfg_pulse_ms,
  input  logic [MS_W-1:0] cfg_settle_ms,
  input  logic [MS_W-1:0] cfg_run_ms,
  input  logic            cfg_sysrst_en,
  input  logic            cfg_trst_pushpull,
  output logic            sysrst_oe,
  output logic            trst_oe,
  output logic            trst_o,
  output logic            halt_req,
  output logic            init_start,
  output logic            ready
);
  import rsq_pkg::*;

  seq_state_e          state;
  logic                phase_enter;
  logic                phase_done;
  logic [MS_W-1:0]     phase_target;
  logic                sys_en_q;
  logic                pp_q;
  logic                assert_phase;
  logic                sys_drive_high;
  logic [NUM_PINS-1:0] pin_assert, pin_en, pin_pp, pin_oe, pin_level;

  rsq_ctrl #(
    .MS_W(MS_W), .DEF_PULSE_MS(DEF_PULSE_MS),
    .RUN_MIN_MS(RUN_MIN_MS), .RUN_MAX_MS(RUN_MAX_MS)
  ) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_req        (start_req),
    .phase_done       (phase_done),
    .cfg_mode         (cfg_mode),
    .cfg_pulse_ms     (cfg_pulse_ms),
    .cfg_settle_ms    (cfg_settle_ms),
    .cfg_run_ms       (cfg_run_ms),
    .cfg_sysrst_en    (cfg_sysrst_en),
    .cfg_trst_pushpull(cfg_trst_pushpull),
    .state_o          (state),
    .phase_enter      (phase_enter),
    .phase_target     (phase_target),
    .sys_en_q         (sys_en_q),
    .pp_q             (pp_q)
  );

  rsq_ms_timer #(.W(MS_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_enter),
    .tick  (ms_tick),
    .target(phase_target),
    .expire(phase_done)
  );

  assign assert_phase = (state == ST_ASSERT);

  always_comb begin
    pin_assert           = '0;
    pin_en               = '0;
    pin_pp               = '0;
    pin_assert[PIN_SYS]  = assert_phase;
    pin_en[PIN_SYS]      = sys_en_q;
    pin_pp[PIN_SYS]      = 1'b0;       // open-collector only
    pin_assert[PIN_TRST] = assert_phase;
    pin_en[PIN_TRST]     = 1'b1;
    pin_pp[PIN_TRST]     = pp_q;
  end

  rsq_pin_drive #(.N(NUM_PINS)) u_pins (
    .assert_i  (pin_assert),
    .enable_i  (pin_en),
    .pushpull_i(pin_pp),
    .oe_o      (pin_oe),
    .level_o   (pin_level)
  );

  assign sys_drive_high = pin_oe[PIN_SYS] & pin_level[PIN_SYS];
  assign sysrst_oe      = pin_oe[PIN_SYS];
  assign trst_oe        = pin_oe[PIN_TRST];
  assign trst_o         = pin_level[PIN_TRST];
  assign halt_req       = (state == ST_HALT);
  assign init_start     = (state == ST_INIT);
  assign ready          = (state == ST_DONE);
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic halt_req,
  input logic init_start,
  input logic ready,
  input logic sysrst_oe,
  input logic trst_oe,
  input logic trst_o,
  input logic sys_drive_high,
  input logic assert_phase,
  input logic sys_en_q,
  input logic pp_q
);
  // R1
  trst_low_in_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    assert_phase |-> (trst_oe && !trst_o));
  // R4
  halt_then_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !start_req) |=> init_start);
  // R4
  init_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_start && !start_req) |=> ready);
  // R7
  sys_suppressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_en_q |-> !sysrst_oe);
  // R8
  sys_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_drive_high);
  // R8
  sys_only_in_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_oe |-> assert_phase);
  // R9
  od_pull_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_q && trst_oe) |-> !trst_o);
  // R9
  pp_always_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pp_q |-> trst_oe);
  // R12
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, init_start, ready}));
  // R12
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start_req) |=> ready);
endmodule

bind probe_reset_sequencer rsq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_req     (start_req),
  .halt_req      (halt_req),
  .init_start    (init_start),
  .ready         (ready),
  .sysrst_oe     (sysrst_oe),
  .trst_oe       (trst_oe),
  .trst_o        (trst_o),
  .sys_drive_high(sys_drive_high),
  .assert_phase  (assert_phase),
  .sys_en_q      (sys_en_q),
  .pp_q          (pp_q)
);

// File: tb/probe_reset_sequencer_tb.sv
module probe_reset_sequencer_tb;
  localparam int MS_W     = 16;
  localparam int TICK_DIV = 4;
  localparam int WD_LIMIT = 190000;

  localparam int EV_ASSERT  = 0;
  localparam int EV_RELEASE = 1;
  localparam int EV_HALT    = 2;
  localparam int EV_INIT    = 3;
  localparam int EV_READY   = 4;

  typedef struct {
    int    code;
    int    delta;   // ticks since previous event, -1 = not checked
    bit    sys;
    bit    pp;
    string req;
  } exp_item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ms_tick = 1'b0;
  logic            start_req = 1'b0;
  logic [1:0]      cfg_mode = 2'b00;
  logic [MS_W-1:0] cfg_pulse_ms = '0;
  logic [MS_W-1:0] cfg_settle_ms = '0;
  logic [MS_W-1:0] cfg_run_ms = '0;
  logic            cfg_sysrst_en = 1'b1;
  logic            cfg_trst_pushpull = 1'b0;
  logic            sysrst_oe, trst_oe, trst_o, halt_req, init_start, ready;

  int        checks = 0;
  int        errors = 0;
  int        tick_acc = 0;
  int        cycles = 0;
  bit        finished = 0;
  bit        prev_low = 0;
  bit        prev_ready = 0;
  exp_item_t exp_q[$];

  probe_reset_sequencer #(.MS_W(MS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start_req(start_req),
    .cfg_mode(cfg_mode), .cfg_pulse_ms(cfg_pulse_ms), .cfg_settle_ms(cfg_settle_ms),
    .cfg_run_ms(cfg_run_ms), .cfg_sysrst_en(cfg_sysrst_en),
    .cfg_trst_pushpull(cfg_trst_pushpull), .sysrst_oe(sysrst_oe), .trst_oe(trst_oe),
    .trst_o(trst_o), .halt_req(halt_req), .init_start(init_start), .ready(ready)
  );

  always #5 clk = ~clk;

  // millisecond tick: one cycle high every TICK_DIV cycles
  initial begin
    forever begin
      for (int i = 0; i < TICK_DIV; i++) begin
        @(posedge clk) #1;
        ms_tick = (i == TICK_DIV - 1);
      end
    end
  end

  function automatic string ev_name(input int code);
    case (code)
      EV_ASSERT:  return "assert";
      EV_RELEASE: return "release";
      EV_HALT:    return "halt";
      EV_INIT:    return "init";
      default:    return "ready";
    endcase
  endfunction

  task automatic push(input int code, input int delta, input bit sys, input bit pp, input string req);
    exp_item_t it;
    it.code = code; it.delta = delta; it.sys = sys; it.pp = pp; it.req = req;
    exp_q.push_back(it);
  endtask

  // Expected event list, restated from the requirements.
  task automatic expect_seq(input int mode, input int pulse, input int settle, input int run,
                            input bit sys, input bit pp);
    int pulse_len, win;
    pulse_len = (pulse == 0) ? 3 : pulse;                        // R2
    win = (run < 100) ? 100 : ((run > 32000) ? 32000 : run);     // R5
    push(EV_ASSERT, -1, sys, pp, sys ? "R1/R8" : "R7");
    push(EV_RELEASE, pulse_len, sys, pp, pp ? "R2/R9" : "R2");
    if (mode == 0) begin
      push(EV_HALT, settle, sys, pp, "R3");
      push(EV_INIT, 0, sys, pp, "R4");
      push(EV_READY, 0, sys, pp, "R4");
    end else if (mode == 1) begin
      push(EV_HALT, settle + win, sys, pp, "R5");
      push(EV_INIT, 0, sys, pp, "R5");
      push(EV_READY, 0, sys, pp, "R5");
    end else begin
      push(EV_READY, settle, sys, pp, "R6");
    end
  endtask

  task automatic got(input int code);
    exp_item_t it;
    bit ok;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R12: unexpected %s event, expected none", ev_name(code));
    end else begin
      it = exp_q.pop_front();
      ok = (it.code == code) && (it.delta < 0 || it.delta == tick_acc);
      if (code == EV_ASSERT) ok = ok && (sysrst_oe == it.sys) && trst_oe;
      else ok = ok && !sysrst_oe && (trst_oe == it.pp) && (!trst_oe || trst_o);
      if (!ok) begin
        errors++;
        $display("FAIL %s: got %s after %0d ticks (sysrst_oe=%0b trst_oe=%0b trst_o=%0b), expected %s after %0d ticks (sys=%0b pp=%0b)",
                 it.req, ev_name(code), tick_acc, sysrst_oe, trst_oe, trst_o,
                 ev_name(it.code), it.delta, it.sys, it.pp);
      end
    end
    tick_acc = 0;
  endtask

  // monitor: turns port activity into events and scores them
  always @(negedge clk) begin
    bit low;
    if (!rst_n) begin
      prev_low = 0; prev_ready = 0; tick_acc = 0;
    end else begin
      low = trst_oe && !trst_o;
      if (low && !prev_low) got(EV_ASSERT);
      if (!low && prev_low) got(EV_RELEASE);
      if (halt_req) got(EV_HALT);
      if (init_start) got(EV_INIT);
      if (ready && !prev_ready) got(EV_READY);
      prev_low = low;
      prev_ready = ready;
      if (ms_tick) tick_acc++;
    end
  end

  task automatic set_cfg(input int mode, input int pulse, input int settle, input int run,
                         input bit sys, input bit pp);
    @(posedge clk) #1;
    cfg_mode = 2'(mode); cfg_pulse_ms = MS_W'(pulse); cfg_settle_ms = MS_W'(settle);
    cfg_run_ms = MS_W'(run); cfg_sysrst_en = sys; cfg_trst_pushpull = pp;
  endtask

  task automatic pulse_start();
    @(posedge clk) #1 start_req = 1'b1;
    @(posedge clk) #1 start_req = 1'b0;
  endtask

  task automatic wait_done();
    do begin
      @(negedge clk) #2;
    end while (!(exp_q.size() == 0 && ready));
    repeat (3) @(posedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: run hung after %0d cycles, expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // power-up configuration: halt policy, default pulse, open-drain
    set_cfg(0, 0, 5, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(!sysrst_oe && !trst_oe && !ready && !halt_req && !init_start, "R1",
          $sformatf("reset state sysrst_oe=%0b trst_oe=%0b ready=%0b, expected all 0",
                    sysrst_oe, trst_oe, ready));
    expect_seq(0, 0, 5, 0, 1, 0);
    @(posedge clk) #1 rst_n = 1'b1;
    wait_done();

    // R10: configuration changes at rest do nothing
    set_cfg(2, 7, 9, 3, 0, 1);
    repeat (100) @(posedge clk);
    @(negedge clk) #1;
    check(ready && !trst_oe && !sysrst_oe && exp_q.size() == 0, "R10",
          $sformatf("after idle cfg change ready=%0b trst_oe=%0b, expected ready=1 trst_oe=0",
                    ready, trst_oe));

    // timed policy below the window minimum
    set_cfg(1, 2, 3, 5, 1, 0);
    expect_seq(1, 2, 3, 5, 1, 0);
    pulse_start();
    wait_done();

    // free-run policy with push-pull test reset
    set_cfg(2, 4, 6, 0, 1, 1);
    expect_seq(2, 4, 6, 0, 1, 1);
    pulse_start();
    wait_done();
    @(negedge clk) #1;
    check(trst_oe && trst_o, "R9",
          $sformatf("push-pull rest trst_oe=%0b trst_o=%0b, expected 1 1", trst_oe, trst_o));

    // system reset suppressed: timing unchanged
    set_cfg(0, 5, 2, 0, 0, 0);
    expect_seq(0, 5, 2, 0, 0, 0);
    pulse_start();
    wait_done();

    // R11: restart during the run window with changed inputs keeps held config
    set_cfg(1, 2, 2, 150, 1, 0);
    expect_seq(1, 2, 2, 150, 1, 0);
    pulse_start();
    do @(negedge clk); while (exp_q.size() > 3);
    repeat (80) @(posedge clk);
    set_cfg(3, 9, 4, 0, 0, 1);
    exp_q = {};
    expect_seq(1, 2, 2, 150, 1, 0);
    pulse_start();
    wait_done();

    // R11: start at rest picks up the new configuration (mode 2'b11 free run)
    expect_seq(3, 9, 4, 0, 0, 1);
    pulse_start();
    wait_done();

    // R5: window above the maximum is limited to 32000
    set_cfg(1, 1, 1, 40000, 1, 0);
    expect_seq(1, 1, 1, 40000, 1, 0);
    pulse_start();
    wait_done();

    check(exp_q.size() == 0, "R12",
          $sformatf("%0d expected events never seen, expected 0", exp_q.size()));
    finish_run();
  end
endmodule